// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is the output stage that sits behind one OR gate of a programmable sum-of-products array. It takes the summed term, its own output-enable term, the two device-wide initialisation terms (an immediate clear and a clocked set) and a two-bit mode setting. From these it produces the pad drive value, the pad drive enable and a feedback bit for the logic array.

Two settings are independent of each other. The first chooses whether the summed term is stored in a flip-flop or passed straight through. The second chooses whether the pad shows that value as it is or inverted. The feedback follows the storage choice. In registered mode it carries the true flip-flop state, so the cell can hold one bit of a state machine. In pass-through mode it carries whatever level is on the pad. When the driver is off, that level is the external pin, so the cell can act as an input, an output or a bidirectional pin.

The flip-flop powers up cleared. A synchronous active-low initialisation input repeats that clear on a clock edge.

Top module: `sop_out_cell`

## Requirements
- R1: Mode bit 1 selects storage: 0 means registered and 1 means pass-through. Mode bit 0 selects polarity: 1 means the pad shows the selected value as it is, and 0 means it shows the value inverted. This holds for all four codes.
- R2: In registered mode the flip-flop loads the summed term on each rising clock edge, and the pad value changes only at that edge.
- R3: In pass-through mode the pad value follows the summed term in the same cycle, with no clock edge needed.
- R4: In registered mode the feedback equals the true flip-flop state. It does not depend on the polarity bit, the enable term or the pad input.
- R5: In pass-through mode the feedback equals the pad drive value while the enable term is 1, and equals the external pad input while the enable term is 0.
- R6: The pad drive enable equals the cell's enable term in every mode.
- R7: When the shared clear term goes to 1, the flip-flop is cleared at once, without waiting for a clock edge. It stays cleared while the term remains 1.
- R8: When the shared set term is 1 at a rising edge, the flip-flop becomes 1 instead of loading the summed term.
- R9: If the clear and set terms are both 1, the clear wins. After the clear is released, a set term that is still 1 takes effect at the next rising edge.
- R10: If the initialisation input is low at a rising edge, the flip-flop is cleared, and this overrides the set term. Afterwards a registered cell shows a pad value of 1 when its polarity bit is 0, and 0 when its polarity bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Synchronous active-low initialisation, clears the flip-flop |
| sum_term | input | 1 | Summed product term from the array |
| oe_term | input | 1 | This cell's output-enable product term |
| clr_term | input | 1 | Shared asynchronous clear term, active high |
| set_term | input | 1 | Shared synchronous set term, active high |
| mode | input | 2 | Bit 1 selects pass-through, bit 0 selects active-high polarity |
| pad_in | input | 1 | Level seen on the pin from outside |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb | output | 1 | Feedback bit to the logic array |

## Verification
The pass-through pad value, the drive enable and the pass-through feedback are due in the same cycle as the inputs that produce them. They are checked one time unit after the inputs change, and always before the next clock edge. Registered results are due one rising edge after the inputs that produce them. The bench applies inputs at the falling edge, updates its own flip-flop model only at the rising edge, and compares during the following low phase. The clear term is the one exception: the bench raises it in the middle of the low phase and checks the pad with no edge in between. It also keeps the clear asserted across an edge while the set term is active, to show the clear wins.

// File: rtl/cell_pkg.sv
// Shared mode decoding for the sum-of-products output cell.
package cell_pkg;

    // Decoded form of the two-bit mode setting.
    typedef struct packed {
        logic passthru;   // 1: bypass the flip-flop
        logic act_high;   // 1: pad shows the selected value as it is
    } cell_mode_t;

    // Splits the raw mode bits into storage and polarity fields.
    function automatic cell_mode_t decode_mode(input logic [1:0] raw);
        cell_mode_t m;
        m.passthru = raw[1];
        m.act_high = raw[0];
        return m;
    endfunction

endpackage

// File: rtl/cell_state_reg.sv
// State flip-flop of the output cell.
// Priority, highest first: the asynchronous clear, then the synchronous
// active-low initialisation, then the synchronous set, then the data input.
// Assumes clr_term is free of glitches, as it comes from a product term.
module cell_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_term,
    input  logic set_term,
    input  logic d,
    output logic q
);

    // Holds the cell state: the clear acts at once, everything else at the edge.
    always_ff @(posedge clk or posedge clr_term) begin
        if (clr_term)       q <= 1'b0;
        else if (!rst_n)    q <= 1'b0;
        else if (set_term)  q <= 1'b1;
        else                q <= d;
    end

    // Records whether a clear occurred since the last edge (used only by checks).
    logic clr_seen;
    always_ff @(posedge clk or posedge clr_term) begin
        if (clr_term) clr_seen <= 1'b1;
        else          clr_seen <= 1'b0;
    end

    // R8: an active set term with no clear makes the state 1 at the edge.
    a_r8_set_loads_one: assert property (@(posedge clk) disable iff (clr_term)
        (set_term && rst_n) |=> (q || clr_seen));

    // R2: with no set and no initialisation, the state takes the data bit.
    a_r2_state_takes_data: assert property (@(posedge clk) disable iff (clr_term)
        (rst_n && !set_term) |=> ((q == $past(d)) || clr_seen));

    // R10: initialisation clears the state even when the set term is active.
    a_r10_init_clears: assert property (@(posedge clk) disable iff (clr_term)
        (!rst_n) |=> (!q || clr_seen));

    // R7 R9: while the clear is held, the state reads 0 at every edge.
    a_r7_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
        clr_term |-> !q);

endmodule

// File: rtl/cell_drive.sv
// Output select and polarity stage of the cell.
// Chooses between the stored state and the live sum, then applies the
// polarity. The drive enable is passed through unchanged.
module cell_drive
    import cell_pkg::*;
(
    input  cell_mode_t mode,
    input  logic       state_q,
    input  logic       sum_term,
    input  logic       oe_term,
    output logic       drv_val,
    output logic       drv_en
);

    logic chosen;

    // Picks the source, then inverts it unless the mode is active high.
    always_comb begin
        chosen  = mode.passthru ? sum_term : state_q;
        drv_val = mode.act_high ? chosen : ~chosen;
        drv_en  = oe_term;
    end

endmodule

// File: rtl/cell_feedback.sv
// Feedback selection for the cell.
// A registered cell returns its true state. A pass-through cell returns the
// pin level, which is its own drive when enabled and the outside level when not.
module cell_feedback
    import cell_pkg::*;
(
    input  cell_mode_t mode,
    input  logic       state_q,
    input  logic       drv_val,
    input  logic       drv_en,
    input  logic       pad_in,
    output logic       fb
);

    logic pin_level;

    // Resolves the pin level, then picks it or the state based on the mode.
    always_comb begin
        pin_level = drv_en ? drv_val : pad_in;
        fb        = mode.passthru ? pin_level : state_q;
    end

endmodule

// File: rtl/sop_out_cell.sv
// Top of the configurable output cell: the state flip-flop, the drive stage
// and the feedback select, wired together.
// Assumes the mode bits are static while the cell is in use, and that the
// pad is resolved outside from pad_out and pad_oe.
module sop_out_cell
    import cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sum_term,
    input  logic       oe_term,
    input  logic       clr_term,
    input  logic       set_term,
    input  logic [1:0] mode,
    input  logic       pad_in,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       fb
);

    cell_mode_t mode_d;
    logic       state_q;

    // Decodes the raw mode bits once for both consumers.
    always_comb mode_d = decode_mode(mode);

    cell_state_reg u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_term (clr_term),
        .set_term (set_term),
        .d        (sum_term),
        .q        (state_q)
    );

    cell_drive u_drive (
        .mode     (mode_d),
        .state_q  (state_q),
        .sum_term (sum_term),
        .oe_term  (oe_term),
        .drv_val  (pad_out),
        .drv_en   (pad_oe)
    );

    cell_feedback u_fb (
        .mode     (mode_d),
        .state_q  (state_q),
        .drv_val  (pad_out),
        .drv_en   (pad_oe),
        .pad_in   (pad_in),
        .fb       (fb)
    );

    // R4: in registered mode the pad is the feedback, after the polarity is applied.
    a_r4_reg_fb_vs_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1]) |-> (pad_out == (mode[0] ? fb : !fb)));

    // R5: a driven pass-through pin feeds back its own drive.
    a_r5_fb_driven_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && pad_oe) |-> (fb == pad_out));

    // R5: an undriven pass-through pin feeds back the outside level.
    a_r5_fb_input_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !pad_oe) |-> (fb == pad_in));

endmodule

// File: tb/sop_out_cell_tb.sv
// Self-checking bench: sweeps every mode against every input combination and
// compares with a behavioural model of the flip-flop.
module sop_out_cell_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sum_term = 1'b0;
    logic       oe_term = 1'b0;
    logic       clr_term = 1'b0;
    logic       set_term = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       pad_in = 1'b0;
    logic       pad_out, pad_oe, fb;

    int  n_checks = 0;
    int  n_errors = 0;
    logic mq = 1'b0;   // bench model of the stored state
    bit  done = 1'b0;

    sop_out_cell u_dut (
        .clk(clk), .rst_n(rst_n), .sum_term(sum_term), .oe_term(oe_term),
        .clr_term(clr_term), .set_term(set_term), .mode(mode),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Updates the model at each rising edge, using the requirement priorities.
    always @(posedge clk) begin
        if (clr_term)      mq <= 1'b0;
        else if (!rst_n)   mq <= 1'b0;
        else if (set_term) mq <= 1'b1;
        else               mq <= sum_term;
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %b expected %b (mode %b)", tag, act, exp, mode);
        end
    endtask

    // Compares all three outputs with values worked out from the requirements.
    task automatic check_all();
        logic sel, pv, ef;
        sel = mode[1] ? sum_term : mq;
        pv  = mode[0] ? sel : ~sel;
        ef  = mode[1] ? (oe_term ? pv : pad_in) : mq;
        check(mode[1] ? "R1 R3 pad" : "R1 R2 pad", pad_out, pv);
        check("R6 enable", pad_oe, oe_term);
        check(mode[1] ? "R5 feedback" : "R4 feedback", fb, ef);
    endtask

    // Applies one input vector at the falling edge and checks the settled outputs.
    task automatic step(input logic s, input logic o, input logic p, input logic st);
        @(negedge clk);
        sum_term = s; oe_term = o; pad_in = p; set_term = st;
        #1;
        check_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // Reset state, checked for both registered polarities (R10).
        @(negedge clk);
        mode = 2'b00; #1; check("R10 init low-pol pad", pad_out, 1'b1);
        mode = 2'b01; #1; check("R10 init high-pol pad", pad_out, 1'b0);
        rst_n = 1'b1;

        // Sweeps every mode with every input combination, in two orders.
        for (int m = 0; m < 4; m++) begin
            @(negedge clk); mode = 2'(m);
            for (int v = 0; v < 16; v++)
                step(v[0], v[1], v[2], v[3]);
            for (int v = 15; v >= 0; v--)
                step(v[2], v[0], v[3], v[1]);
            for (int v = 0; v < 16; v++)
                step(v[3] ^ v[0], v[2], v[1], 1'b0);
        end

        // R8: the set overrides a zero sum at the edge.
        mode = 2'b01;
        step(1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 set state", fb, 1'b1);

        // R7: the clear takes effect mid-cycle with no clock edge.
        step(1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); #1;
        clr_term = 1'b1; #1;
        check("R7 immediate clear pad", pad_out, 1'b0);
        check("R7 immediate clear fb", fb, 1'b0);
        if (mq == 1'b1) mq = 1'b0;   // model the clear between edges

        // R9: clear held across an edge with the set active keeps the state 0.
        step(1'b0, 1'b1, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R9 clear beats set", fb, 1'b0);
        @(negedge clk); clr_term = 1'b0; #1;
        check_all();
        step(1'b0, 1'b1, 1'b0, 1'b1);
        check("R9 set after release", fb, 1'b1);

        // R10: initialisation beats the set, in the active-low registered mode.
        @(negedge clk); mode = 2'b00; rst_n = 1'b0; set_term = 1'b1;
        @(negedge clk); #1;
        check("R10 init beats set fb", fb, 1'b0);
        check("R10 init beats set pad", pad_out, 1'b1);
        rst_n = 1'b1; set_term = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule